// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits in front of the ALU of a five-stage in-order pipeline with eight architectural registers. For each of the two source operands of the instruction now in execute, it looks at the register target of the three instructions ahead of it. Those are the one in the execute/memory register, the one in the memory/writeback register, and the one held one cycle past writeback. When one of them is about to write the register that the operand names, the block replaces the stale register-file value with that newer result.

The second source specifier arrives already resolved by decode. For store and branch instructions it names the register holding store data or the comparand. The block therefore never looks at an opcode: store data and branch operands are forwarded through the second-operand path like any other value. Register 0 is hard-wired to zero. Instructions with no destination carry target 0, so a specifier of 0 never selects a forwarded value. The block is purely combinational. It drives a 2-bit select per operand and the selected 16-bit operand value.

Top module: `fwd_unit`

## Requirements
- R1: When no older target equals a non-zero source specifier, that operand's select is 2'b00 and its output equals the value read in decode.
- R2: When only the execute/memory target matches a non-zero source, the select is 2'b01 and the output is the execute/memory result.
- R3: When only the memory/writeback target matches a non-zero source, the select is 2'b10 and the output is the memory/writeback result.
- R4: When only the post-writeback target matches a non-zero source, the select is 2'b11 and the output is the post-writeback result.
- R5: When several targets match, the nearest producer wins: execute/memory before memory/writeback before post-writeback.
- R6: A source specifier of 0 always gives select 2'b00 and the decode value, even when any target is also 0 (stores, branches, bubbles).
- R7: The two operands are resolved independently. The second operand, which carries store data and branch comparands, may pick a different stage from the first.
- R8: Each operand output always equals the data input named by its select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | 3 | First source specifier of the execute-stage instruction |
| ex_src_b_idx | input | 3 | Second source specifier (already resolved in decode) |
| ex_src_a_val | input | 16 | First operand value read in decode |
| ex_src_b_val | input | 16 | Second operand value read in decode |
| exmem_tgt | input | 3 | Target register of the execute/memory instruction |
| exmem_val | input | 16 | Result held in execute/memory |
| memwb_tgt | input | 3 | Target register of the memory/writeback instruction |
| memwb_val | input | 16 | Result held in memory/writeback |
| postwb_tgt | input | 3 | Target register of the instruction one cycle past writeback |
| postwb_val | input | 16 | Result held after writeback |
| src_a_sel | output | 2 | First operand select (00 decode, 01 ex/mem, 10 mem/wb, 11 post-wb) |
| src_b_sel | output | 2 | Second operand select, same encoding |
| src_a_fwd | output | 16 | Resolved first operand |
| src_b_fwd | output | 16 | Resolved second operand |

## Verification
Each stage is first made the only match, which separates the three select codes and shows that the data mux follows them. The bench then sets up two-way and three-way matches on one register, which shows the nearest stage wins and not the oldest or a blend. Register 0 is driven as both source and target to show that the zero register never forwards. In further patterns the two operands hit different stages, and a store-style case has only the second operand match, so that cross-talk between the two paths would be seen.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int IDX_W    = 3;
    localparam int DATA_W   = 16;
    localparam int NUM_PROD = 3;   // producers: 0 ex/mem, 1 mem/wb, 2 post-wb
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DECODE = 2'b00,
        SEL_EXMEM  = 2'b01,
        SEL_MEMWB  = 2'b10,
        SEL_POSTWB = 2'b11
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel;
        logic     any_hit;
    } prio_res_t;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int IDX_W    = fwd_pkg::IDX_W,
    parameter int NUM_PROD = fwd_pkg::NUM_PROD
) (
    input  logic [IDX_W-1:0]                src_idx,
    input  logic [NUM_PROD-1:0][IDX_W-1:0]  prod_tgt,
    output logic [NUM_PROD-1:0]             hit
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic src_live;
    assign src_live = (src_idx != ZERO_IDX);

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_cmp
        assign hit[p] = src_live && (prod_tgt[p] == src_idx);
    end
endmodule

// File: rtl/fwd_prio_sel.sv
module fwd_prio_sel
    import fwd_pkg::*;
(
    input  logic [NUM_PROD-1:0] hit,
    output fwd_sel_e            sel
);
    prio_res_t res_d;

    always_comb begin
        res_d = '{sel: SEL_DECODE, any_hit: 1'b0};
        if (hit[0]) begin
            res_d = '{sel: SEL_EXMEM, any_hit: 1'b1};
        end else if (hit[1]) begin
            res_d = '{sel: SEL_MEMWB, any_hit: 1'b1};
        end else if (hit[2]) begin
            res_d = '{sel: SEL_POSTWB, any_hit: 1'b1};
        end
    end

    assign sel = res_d.sel;
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  fwd_sel_e            sel,
    input  logic [DATA_W-1:0]   dec_val,
    input  logic [DATA_W-1:0]   exmem_val,
    input  logic [DATA_W-1:0]   memwb_val,
    input  logic [DATA_W-1:0]   postwb_val,
    output logic [DATA_W-1:0]   opnd
);
    always_comb begin
        unique case (sel)
            SEL_EXMEM:  opnd = exmem_val;
            SEL_MEMWB:  opnd = memwb_val;
            SEL_POSTWB: opnd = postwb_val;
            default:    opnd = dec_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int IDX_W  = fwd_pkg::IDX_W,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic [IDX_W-1:0]  ex_src_a_idx,
    input  logic [IDX_W-1:0]  ex_src_b_idx,
    input  logic [DATA_W-1:0] ex_src_a_val,
    input  logic [DATA_W-1:0] ex_src_b_val,
    input  logic [IDX_W-1:0]  exmem_tgt,
    input  logic [DATA_W-1:0] exmem_val,
    input  logic [IDX_W-1:0]  memwb_tgt,
    input  logic [DATA_W-1:0] memwb_val,
    input  logic [IDX_W-1:0]  postwb_tgt,
    input  logic [DATA_W-1:0] postwb_val,
    output logic [1:0]        src_a_sel,
    output logic [1:0]        src_b_sel,
    output logic [DATA_W-1:0] src_a_fwd,
    output logic [DATA_W-1:0] src_b_fwd
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][IDX_W-1:0]   src_idx;
    logic [NUM_SRC-1:0][DATA_W-1:0]  src_val;
    logic [NUM_PROD-1:0][IDX_W-1:0]  prod_tgt;
    logic [NUM_SRC-1:0][NUM_PROD-1:0] hit;
    fwd_sel_e                        sel     [NUM_SRC];
    logic [NUM_SRC-1:0][DATA_W-1:0]  opnd;

    assign src_idx  = {ex_src_b_idx, ex_src_a_idx};
    assign src_val  = {ex_src_b_val, ex_src_a_val};
    assign prod_tgt = {postwb_tgt, memwb_tgt, exmem_tgt};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        fwd_match #(.IDX_W(IDX_W), .NUM_PROD(NUM_PROD)) match_i (
            .src_idx  (src_idx[s]),
            .prod_tgt (prod_tgt),
            .hit      (hit[s])
        );

        fwd_prio_sel prio_i (
            .hit (hit[s]),
            .sel (sel[s])
        );

        fwd_operand_mux #(.DATA_W(DATA_W)) mux_i (
            .sel        (sel[s]),
            .dec_val    (src_val[s]),
            .exmem_val  (exmem_val),
            .memwb_val  (memwb_val),
            .postwb_val (postwb_val),
            .opnd       (opnd[s])
        );
    end

    assign src_a_sel = sel[0];
    assign src_b_sel = sel[1];
    assign src_a_fwd = opnd[0];
    assign src_b_fwd = opnd[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input logic [IDX_W-1:0]  ex_src_a_idx,
    input logic [IDX_W-1:0]  ex_src_b_idx,
    input logic [DATA_W-1:0] ex_src_a_val,
    input logic [DATA_W-1:0] ex_src_b_val,
    input logic [IDX_W-1:0]  exmem_tgt,
    input logic [DATA_W-1:0] exmem_val,
    input logic [IDX_W-1:0]  memwb_tgt,
    input logic [DATA_W-1:0] memwb_val,
    input logic [IDX_W-1:0]  postwb_tgt,
    input logic [DATA_W-1:0] postwb_val,
    input logic [1:0]        src_a_sel,
    input logic [1:0]        src_b_sel,
    input logic [DATA_W-1:0] src_a_fwd,
    input logic [DATA_W-1:0] src_b_fwd
);
    always_comb begin
        // R6: the zero register never forwards
        a_r6_zero_src_a: assert (ex_src_a_idx != '0 || src_a_sel == 2'b00)
            else $error("zero source A forwarded");
        a_r6_zero_src_b: assert (ex_src_b_idx != '0 || src_b_sel == 2'b00)
            else $error("zero source B forwarded");
        // R1: no matching producer keeps the decode value
        a_r1_no_match_a: assert (!(ex_src_a_idx != exmem_tgt && ex_src_a_idx != memwb_tgt
                                   && ex_src_a_idx != postwb_tgt) || src_a_fwd == ex_src_a_val)
            else $error("operand A changed without a match");
        // R5: nearest producer has priority
        a_r5_nearest_a: assert (!(ex_src_a_idx != '0 && ex_src_a_idx == exmem_tgt)
                                || src_a_sel == 2'b01)
            else $error("ex/mem match not preferred on A");
        a_r5_nearest_b: assert (!(ex_src_b_idx != '0 && ex_src_b_idx == exmem_tgt)
                                || src_b_sel == 2'b01)
            else $error("ex/mem match not preferred on B");
        // R8: data follows select
        a_r8_mux_a: assert ((src_a_sel == 2'b00 && src_a_fwd == ex_src_a_val) ||
                            (src_a_sel == 2'b01 && src_a_fwd == exmem_val)    ||
                            (src_a_sel == 2'b10 && src_a_fwd == memwb_val)    ||
                            (src_a_sel == 2'b11 && src_a_fwd == postwb_val))
            else $error("operand A does not follow its select");
        a_r8_mux_b: assert ((src_b_sel == 2'b00 && src_b_fwd == ex_src_b_val) ||
                            (src_b_sel == 2'b01 && src_b_fwd == exmem_val)    ||
                            (src_b_sel == 2'b10 && src_b_fwd == memwb_val)    ||
                            (src_b_sel == 2'b11 && src_b_fwd == postwb_val))
            else $error("operand B does not follow its select");
    end
endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .ex_src_a_val (ex_src_a_val),
    .ex_src_b_val (ex_src_b_val),
    .exmem_tgt    (exmem_tgt),
    .exmem_val    (exmem_val),
    .memwb_tgt    (memwb_tgt),
    .memwb_val    (memwb_val),
    .postwb_tgt   (postwb_tgt),
    .postwb_val   (postwb_val),
    .src_a_sel    (src_a_sel),
    .src_b_sel    (src_b_sel),
    .src_a_fwd    (src_a_fwd),
    .src_b_fwd    (src_b_fwd)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [2:0]  a_idx, b_idx, t0, t1, t2;
    logic [15:0] a_val, b_val, v0, v1, v2;
    logic [1:0]  a_sel, b_sel;
    logic [15:0] a_fwd, b_fwd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    fwd_unit dut_i (
        .ex_src_a_idx (a_idx), .ex_src_b_idx (b_idx),
        .ex_src_a_val (a_val), .ex_src_b_val (b_val),
        .exmem_tgt (t0), .exmem_val (v0),
        .memwb_tgt (t1), .memwb_val (v1),
        .postwb_tgt (t2), .postwb_val (v2),
        .src_a_sel (a_sel), .src_b_sel (b_sel),
        .src_a_fwd (a_fwd), .src_b_fwd (b_fwd)
    );

    task automatic drive(input logic [2:0] ia, input logic [2:0] ib,
                         input logic [2:0] x0, input logic [2:0] x1, input logic [2:0] x2);
        @(posedge clk);
        a_idx = ia; b_idx = ib; t0 = x0; t1 = x1; t2 = x2;
        a_val = 16'h1111; b_val = 16'h2222;
        v0 = 16'hAAA0; v1 = 16'hBBB1; v2 = 16'hCCC2;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] es_a, input logic [15:0] ed_a,
                         input logic [1:0] es_b, input logic [15:0] ed_b);
        checks++;
        if (a_sel !== es_a || a_fwd !== ed_a || b_sel !== es_b || b_fwd !== ed_b) begin
            failures++;
            $display("FAIL %s: got a_sel=%b a=%h b_sel=%b b=%h expected a_sel=%b a=%h b_sel=%b b=%h",
                     req, a_sel, a_fwd, b_sel, b_fwd, es_a, ed_a, es_b, ed_b);
        end
    endtask

    task automatic t_idle();          // R1 after reset, all zero
        drive(3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
        check("R1 idle", 2'b00, 16'h1111, 2'b00, 16'h2222);
        drive(3'd3, 3'd4, 3'd5, 3'd6, 3'd7);
        check("R1 no match", 2'b00, 16'h1111, 2'b00, 16'h2222);
    endtask

    task automatic t_single();        // R2 R3 R4
        drive(3'd2, 3'd1, 3'd2, 3'd5, 3'd6);
        check("R2 ex/mem only", 2'b01, 16'hAAA0, 2'b00, 16'h2222);
        drive(3'd2, 3'd1, 3'd4, 3'd2, 3'd6);
        check("R3 mem/wb only", 2'b10, 16'hBBB1, 2'b00, 16'h2222);
        drive(3'd2, 3'd1, 3'd4, 3'd5, 3'd2);
        check("R4 post-wb only", 2'b11, 16'hCCC2, 2'b00, 16'h2222);
    endtask

    task automatic t_priority();      // R5
        drive(3'd5, 3'd0, 3'd5, 3'd5, 3'd5);
        check("R5 three-way", 2'b01, 16'hAAA0, 2'b00, 16'h2222);
        drive(3'd5, 3'd0, 3'd1, 3'd5, 3'd5);
        check("R5 mem/wb over post-wb", 2'b10, 16'hBBB1, 2'b00, 16'h2222);
        drive(3'd5, 3'd0, 3'd5, 3'd1, 3'd5);
        check("R5 ex/mem over post-wb", 2'b01, 16'hAAA0, 2'b00, 16'h2222);
    endtask

    task automatic t_zero();          // R6
        drive(3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
        check("R6 zero targets", 2'b00, 16'h1111, 2'b00, 16'h2222);
        drive(3'd0, 3'd0, 3'd0, 3'd3, 3'd0);
        check("R6 zero source mixed", 2'b00, 16'h1111, 2'b00, 16'h2222);
    endtask

    task automatic t_independent();   // R7 R8
        drive(3'd3, 3'd6, 3'd6, 3'd7, 3'd3);
        check("R7 split stages", 2'b11, 16'hCCC2, 2'b01, 16'hAAA0);
        drive(3'd1, 3'd4, 3'd2, 3'd4, 3'd0);
        check("R7 store data only", 2'b00, 16'h1111, 2'b10, 16'hBBB1);
        drive(3'd7, 3'd7, 3'd0, 3'd7, 3'd7);
        check("R8 same reg both", 2'b10, 16'hBBB1, 2'b10, 16'hBBB1);
    endtask

    initial begin
        a_idx = '0; b_idx = '0; t0 = '0; t1 = '0; t2 = '0;
        a_val = '0; b_val = '0; v0 = '0; v1 = '0; v2 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_single();
        t_priority();
        t_zero();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule